// File: doc/BRIEF.md
# Shared Hub Memory with Build-Time Region Protection

This block is the shared long-wide memory that several processing cores reach through an external arbiter. It is organised as four byte-wide banks, one per byte lane, so a single access can update any subset of the four bytes of a long. Its address space is split into four regions by the top four address bits. The lower half is plain read/write storage. A font region follows, then a region for math tables and code. The top sixteenth is a protected region that no write can reach.

Build parameters decide what each of the two middle regions is. Each can be read-only preloaded storage, writable storage that still starts out holding its preload, or removed entirely. A third parameter picks one of three preload images, and a constant version output reports which image was built in. Preload contents are computed at elaboration time, so no file is read. A full build uses a 16-bit byte address (64 KB). The default is a scaled 11-bit build with the same region proportions.

Each access takes one cycle. The caller presents a long-aligned byte address, lane enables, write data and a write strobe. The read data for that address appears one clock later.

Top module: `hub_mem`

## Requirements
- R1: Long indices whose top region bits are 0 to 7 (the lower half) are writable; data written there is returned by a later read of the same address.
- R2: Byte-enable bit k selects lane k, which holds data bits 8k+7:8k (bit 0 for bits 7:0, bit 3 for bits 31:24); lanes whose enable bit is 0 keep their old contents.
- R3: Region 15 (the top sixteenth of the space) is never changed by any write, whatever the build parameters.
- R4: Region 8 to 11 (font) acts per FONT_MODE: REGION_ROM (0) keeps its preload and ignores writes; REGION_RAM (1) starts with the preload and accepts writes; REGION_ABSENT (2) ignores writes and reads as zero.
- R5: Region 12 to 14 (tables and code) acts per HIGH_MODE with the same three encodings and behaviour as R4.
- R6: At start-up every byte above the lower half holds preload value L[7:0] ^ (k*0x11) ^ (IMAGE*0x40), with L the long index, k the lane and IMAGE in 0..2; the lower half starts at zero.
- R7: The version output equals IMAGE+1, giving 1, 2 or 3.
- R8: Read data is registered: it is zero while reset is held and after reset until the first read edge, and it shows the addressed long one clock edge after the address is presented, not before.
- R9: When the write strobe is low, nothing is stored, whatever the byte enables and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| addr | input | BYTE_ADDR_W | Byte address; bits 1:0 are ignored |
| byteEn | input | 4 | Per-lane write enable |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdData | output | 32 | Registered read data |
| version | output | 2 | Preload image identifier |

## Verification
The assertions assume that address, byte enables, data and the write strobe are stable around each rising edge. They also assume a read-back check only applies when the same long index is held for the cycle after a write with the strobe low. The bench changes inputs only on falling edges. It keeps every read as its own cycle with the write strobe low, so no read and write to one long share an edge. The absent-region check assumes that the build parameters hold only the three defined mode encodings, and the bench builds only those.

// File: rtl/hub_mem_pkg.sv
package hub_mem_pkg;

  typedef enum logic [1:0] {
    REGION_ROM    = 2'd0,
    REGION_RAM    = 2'd1,
    REGION_ABSENT = 2'd2
  } regionMode_e;

  typedef struct packed {
    logic [3:0] wrLane;
    logic       zeroRead;
  } memStrobe_t;

  localparam int unsigned LANES = 4;

  function automatic logic [7:0] preloadByte(int unsigned longIdx, int unsigned lane,
                                             int unsigned image);
    return 8'(longIdx) ^ 8'(lane * 17) ^ 8'(image * 64);
  endfunction

  function automatic logic [1:0] versionId(int unsigned image);
    return 2'(image + 1);
  endfunction

endpackage

// File: rtl/hub_mem_ctrl.sv
module hub_mem_ctrl
  import hub_mem_pkg::*;
#(
  parameter int unsigned LONG_W    = 9,
  parameter regionMode_e FONT_MODE = REGION_ROM,
  parameter regionMode_e HIGH_MODE = REGION_ROM
) (
  input  logic [LONG_W-1:0] longIdx,
  input  logic [3:0]        byteEn,
  input  logic              wrEn,
  output memStrobe_t        strb
);

  logic [3:0] region;
  logic inLow, inFont, inHigh, isWritable, isAbsent;

  always_comb begin
    region     = longIdx[LONG_W-1 -: 4];
    inLow      = !region[3];
    inFont     = (region[3:2] == 2'b10);
    inHigh     = (region[3:2] == 2'b11) && (region != 4'hF);
    isWritable = inLow
               || (inFont && (FONT_MODE == REGION_RAM))
               || (inHigh && (HIGH_MODE == REGION_RAM));
    isAbsent   = (inFont && (FONT_MODE == REGION_ABSENT))
               || (inHigh && (HIGH_MODE == REGION_ABSENT));
    strb.wrLane   = (wrEn && isWritable && !isAbsent) ? byteEn : 4'b0000;
    strb.zeroRead = isAbsent;
  end

endmodule

// File: rtl/hub_mem_lane.sv
module hub_mem_lane
  import hub_mem_pkg::*;
#(
  parameter int unsigned LONG_W = 9,
  parameter int unsigned LANE   = 0,
  parameter int unsigned IMAGE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LONG_W-1:0] idx,
  input  logic [7:0]        wd,
  output logic [7:0]        q
);

  localparam int unsigned DEPTH = 1 << LONG_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = (i < DEPTH / 2) ? 8'h00 : preloadByte(i, LANE, IMAGE);
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mem[idx];
  end

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we ##1 (!we && idx == $past(idx))) |=> (q == $past(wd, 2))); // R1

endmodule

// File: rtl/hub_mem_data.sv
module hub_mem_data
  import hub_mem_pkg::*;
#(
  parameter int unsigned LONG_W    = 9,
  parameter int unsigned IMAGE     = 0,
  parameter regionMode_e FONT_MODE = REGION_ROM,
  parameter regionMode_e HIGH_MODE = REGION_ROM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LONG_W-1:0] longIdx,
  input  logic [31:0]       wrData,
  input  logic              wrEn,
  input  memStrobe_t        strb,
  output logic [31:0]       rdData
);

  logic [LANES-1:0][7:0] laneQ;
  logic                  zeroQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    hub_mem_lane #(
      .LONG_W(LONG_W),
      .LANE  (g),
      .IMAGE (IMAGE)
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (strb.wrLane[g]),
      .idx  (longIdx),
      .wd   (wrData[8*g +: 8]),
      .q    (laneQ[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zeroQ <= 1'b0;
    else        zeroQ <= strb.zeroRead;
  end

  assign rdData = zeroQ ? 32'h0 : laneQ;

  logic [3:0] regionBits;
  assign regionBits = longIdx[LONG_W-1 -: 4];

  AST_TOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrLane != 4'b0) |-> (regionBits != 4'hF)); // R3
  AST_FONT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((FONT_MODE != REGION_RAM) && regionBits >= 4'd8 && regionBits <= 4'd11)
      |-> (strb.wrLane == 4'b0)); // R4
  AST_HIGH_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((HIGH_MODE != REGION_RAM) && regionBits >= 4'd12 && regionBits <= 4'd14)
      |-> (strb.wrLane == 4'b0)); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (strb.wrLane == 4'b0)); // R9

endmodule

// File: rtl/hub_mem.sv
module hub_mem
  import hub_mem_pkg::*;
#(
  parameter int unsigned BYTE_ADDR_W = 11,
  parameter regionMode_e FONT_MODE   = REGION_ROM,
  parameter regionMode_e HIGH_MODE   = REGION_ROM,
  parameter int unsigned IMAGE       = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BYTE_ADDR_W-1:0] addr,
  input  logic [3:0]             byteEn,
  input  logic [31:0]            wrData,
  input  logic                   wrEn,
  output logic [31:0]            rdData,
  output logic [1:0]             version
);

  localparam int unsigned LONG_W = BYTE_ADDR_W - 2;

  logic [LONG_W-1:0] longIdx;
  logic              unusedByteOffset;
  memStrobe_t        strb;

  assign longIdx          = addr[BYTE_ADDR_W-1:2];
  assign unusedByteOffset = ^addr[1:0];
  assign version          = versionId(IMAGE);

  hub_mem_ctrl #(
    .LONG_W   (LONG_W),
    .FONT_MODE(FONT_MODE),
    .HIGH_MODE(HIGH_MODE)
  ) u_ctrl (
    .longIdx(longIdx),
    .byteEn (byteEn),
    .wrEn   (wrEn),
    .strb   (strb)
  );

  hub_mem_data #(
    .LONG_W   (LONG_W),
    .IMAGE    (IMAGE),
    .FONT_MODE(FONT_MODE),
    .HIGH_MODE(HIGH_MODE)
  ) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .longIdx(longIdx),
    .wrData (wrData),
    .wrEn   (wrEn),
    .strb   (strb),
    .rdData (rdData)
  );

  logic absentNow;
  assign absentNow =
      (addr[BYTE_ADDR_W-1 -: 2] == 2'b10 && FONT_MODE == REGION_ABSENT)
   || (addr[BYTE_ADDR_W-1 -: 2] == 2'b11 && addr[BYTE_ADDR_W-1 -: 4] != 4'hF
       && HIGH_MODE == REGION_ABSENT);

  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    absentNow |=> (rdData == 32'h0)); // R4 R5

endmodule

// File: tb/hub_mem_tb.sv
`timescale 1ns/1ps
module hub_mem_tb;
  import hub_mem_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rd [3];
  logic [1:0]  ver [3];

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hub_mem #(.BYTE_ADDR_W(11), .FONT_MODE(REGION_ROM), .HIGH_MODE(REGION_ROM), .IMAGE(0))
    u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .byteEn(byteEn), .wrData(wrData),
           .wrEn(wrEn), .rdData(rd[0]), .version(ver[0]));
  hub_mem #(.BYTE_ADDR_W(11), .FONT_MODE(REGION_RAM), .HIGH_MODE(REGION_RAM), .IMAGE(1))
    u_dut2 (.clk(clk), .rst_n(rst_n), .addr(addr), .byteEn(byteEn), .wrData(wrData),
            .wrEn(wrEn), .rdData(rd[1]), .version(ver[1]));
  hub_mem #(.BYTE_ADDR_W(11), .FONT_MODE(REGION_ABSENT), .HIGH_MODE(REGION_ABSENT), .IMAGE(2))
    u_dut3 (.clk(clk), .rst_n(rst_n), .addr(addr), .byteEn(byteEn), .wrData(wrData),
            .wrEn(wrEn), .rdData(rd[2]), .version(ver[2]));

  // Mode per instance: 0 read-only, 1 writable, 2 removed
  localparam int MODE [3] = '{0, 1, 2};
  localparam int IMG  [3] = '{0, 1, 2};

  logic [7:0] shadow [3][512][4];

  function automatic logic [7:0] expPre(int l, int k, int img);
    return 8'(l) ^ 8'(k * 8'h11) ^ 8'(img * 8'h40);
  endfunction

  function automatic bit isAbsent(int d, int l);
    int r = l >> 5;
    return (r >= 8 && r <= 14) && MODE[d] == 2;
  endfunction

  function automatic bit canWrite(int d, int l);
    int r = l >> 5;
    return (r < 8) || ((r >= 8 && r <= 14) && MODE[d] == 1);
  endfunction

  function automatic logic [31:0] expRead(int d, int l);
    if (isAbsent(d, l)) return 32'h0;
    return {shadow[d][l][3], shadow[d][l][2], shadow[d][l][1], shadow[d][l][0]};
  endfunction

  task automatic check(int d, int tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d dut%0d: actual %h expected %h", tag, d, act, exp);
    end
  endtask

  // One access: inputs set at a falling edge, result sampled at the next one
  task automatic access(bit we, logic [10:0] a, logic [3:0] be, logic [31:0] dat);
    wrEn = we; addr = a; byteEn = be; wrData = dat;
    @(negedge clk);
    if (we) begin
      for (int d = 0; d < 3; d++) begin
        if (canWrite(d, int'(a >> 2)))
          for (int k = 0; k < 4; k++)
            if (be[k]) shadow[d][a >> 2][k] = dat[8*k +: 8];
      end
    end
    wrEn = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [10:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 11'h010, 4'hF, 32'hDEADBEEF, 4'd1},  // R1 full write low half
    '{1'b0, 11'h010, 4'h0, 32'h0,        4'd1},
    '{1'b1, 11'h010, 4'h5, 32'h11223344, 4'd2},  // R2 lanes 0 and 2
    '{1'b0, 11'h010, 4'h0, 32'h0,        4'd2},
    '{1'b0, 11'h404, 4'h0, 32'h0,        4'd6},  // R6 font preload
    '{1'b1, 11'h404, 4'hF, 32'hCAFEF00D, 4'd4},  // R4 font write
    '{1'b0, 11'h404, 4'h0, 32'h0,        4'd4},
    '{1'b0, 11'h600, 4'h0, 32'h0,        4'd6},  // R6 high preload
    '{1'b1, 11'h600, 4'h3, 32'h0000ABCD, 4'd5},  // R5 high write
    '{1'b0, 11'h600, 4'h0, 32'h0,        4'd5},
    '{1'b1, 11'h7FC, 4'hF, 32'h12345678, 4'd3},  // R3 top write
    '{1'b0, 11'h7FC, 4'h0, 32'h0,        4'd3},
    '{1'b1, 11'h3FC, 4'h8, 32'hAA000000, 4'd2},  // R2 lane 3 only
    '{1'b0, 11'h3FC, 4'h0, 32'h0,        4'd2},
    '{1'b0, 11'h782, 4'h0, 32'h0,        4'd6},  // R6 top preload, offset ignored
    '{1'b0, 11'h5FC, 4'h0, 32'h0,        4'd4}   // R4 last font long
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++)
      for (int l = 0; l < 512; l++)
        for (int k = 0; k < 4; k++)
          shadow[d][l][k] = (l < 256) ? 8'h00 : expPre(l, k, IMG[d]);

    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) check(d, 8, rd[d], 32'h0);          // R8 reset value
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++) check(d, 7, 32'(ver[d]), d + 1);    // R7 version

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].data);
      if (!VEC[i].we)
        for (int d = 0; d < 3; d++)
          check(d, int'(VEC[i].tag), rd[d], expRead(d, int'(VEC[i].addr >> 2)));
    end

    // R9: strobe low with enables and data set, then read back
    access(1'b0, 11'h020, 4'hF, 32'h55AA55AA);
    shadow[0][8][0] = shadow[0][8][0];
    access(1'b0, 11'h020, 4'h0, 32'h0);
    for (int d = 0; d < 3; d++) check(d, 9, rd[d], 32'h0);

    // R8: new address not visible before the edge, visible after it
    access(1'b1, 11'h030, 4'hF, 32'h0BADC0DE);
    access(1'b0, 11'h030, 4'h0, 32'h0);
    addr = 11'h010;
    #2.0;
    for (int d = 0; d < 3; d++) check(d, 8, rd[d], 32'h0BADC0DE);
    @(negedge clk);
    for (int d = 0; d < 3; d++) check(d, 8, rd[d], expRead(d, 4));

    // R1: boundary at the last long of the lower half, all lanes
    access(1'b1, 11'h3FC, 4'hF, 32'h87654321);
    access(1'b0, 11'h3FC, 4'h0, 32'h0);
    for (int d = 0; d < 3; d++) check(d, 1, rd[d], 32'h87654321);

    // R3: writes to the top region leave it at its preload in every build
    access(1'b1, 11'h7C0, 4'hF, 32'hFFFFFFFF);
    access(1'b0, 11'h7C0, 4'h0, 32'h0);
    for (int d = 0; d < 3; d++) check(d, 3, rd[d], expRead(d, 11'h7C0 >> 2));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule